// File: doc/BRIEF.md
# Streaming Buffer Write Controller

This block accepts decoded stream configure commands and stream data words for up to three write channels, and turns every accepted data word into a memory write request that lands inside the region the channel was configured with. Each channel has a destination node address for its alerts, a buffer start address, a buffer length, and a choice between single-buffer and double-buffer operation.

In single-buffer operation the channel raises one alert when its last buffer word is written and then refuses data until it is configured again. In double-buffer operation it raises an alert when the first half of the buffer is filled and another when the second half is filled. It then wraps back to the buffer start, so a consumer can drain one half while the other half fills. Alerts wait in a two-entry queue until the consumer takes them. A word sent to a channel that cannot take it is discarded, and that channel's sticky overflow flag is set.

Top module: `stream_buf_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, `wr_valid` and `alert_valid` are 0 and `ovf_flag` is all zero. Every channel starts unconfigured.
- R2: A configure frame is taken only when `cfg_word0[23]` is 1 and `cfg_word0[22:21]` is not 00. That field value (1, 2 or 3) names the channel. `cfg_word0[31:24]` is the alert destination, `cfg_word0[20]` selects double-buffer mode, `cfg_word0[19:0]` is the buffer length in words minus one, and `cfg_word1` with bits 1:0 forced to zero is the buffer start address. Any other frame changes nothing.
- R3: The k-th word accepted since a channel was configured or last wrapped (k counting from 0) produces `wr_valid`=1, `wr_addr` = start + 4k and `wr_data` equal to the word, in the cycle after the word is presented.
- R4: In single-buffer mode, accepting word k = length-1 queues one alert with start address = buffer start and length field = length-1. Words sent afterwards produce no write and set the channel's overflow flag.
- R5: In double-buffer mode with H = floor(length/2) and H > 0, accepting word k = H-1 queues an alert with start address = buffer start and length field = H-1.
- R6: In double-buffer mode, accepting word k = length-1 queues an alert with start address = buffer start + 4H and length field = length-1-H. The next accepted word is written at the buffer start again.
- R7: A word for an unconfigured or locked channel is discarded, with no write, and sets that channel's bit of `ovf_flag` (bit c-1 for channel c). A configure of the channel clears its flag and makes it accept words from offset 0.
- R8: A queued alert appears on `alert_dest` (the configured destination), `alert_word0` = {`node_addr`, 3'b100, 1'b0, length field}, and `alert_word1` = valid start address.
- R9: Alerts leave the queue in the order they were raised and are held stable until accepted with `alert_ready`. The queue holds 2 alerts. An alert raised while the queue is full and not being popped is lost.
- R10: `dat_chan` values 1, 2 and 3 select channel 1, 2 and 3. A word with `dat_chan` = 0 is ignored: it produces no write and sets no flag. Each channel's state is independent of traffic on the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | 8 | Address of this node, placed in alert word 0 |
| cfg_valid | input | 1 | Configure frame present this cycle |
| cfg_word0 | input | 32 | First configure word |
| cfg_word1 | input | 32 | Second configure word (buffer start address) |
| dat_valid | input | 1 | Stream data word present this cycle |
| dat_chan | input | 2 | Channel code of the data word (1..3) |
| dat_word | input | 32 | Stream data word |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| ovf_flag | output | 3 | Sticky per-channel discard flags |
| alert_valid | output | 1 | Alert at queue head |
| alert_ready | input | 1 | Consumer takes the head alert |
| alert_dest | output | 8 | Destination address of the head alert |
| alert_word0 | output | 32 | Alert word 0: source node, tag, length field |
| alert_word1 | output | 32 | Alert word 1: valid data start address |

## Verification
The bench aims at the points where a buffer pointer is most easily off by one. It checks the last word of a single-buffer region, where a wrong compare either locks one word early or writes past the buffer without locking. It checks the half point of an odd-length double buffer, where a rounding error shifts both alerts and the start address of the second half. It checks the wrap back to the buffer start, which a broken design would skip by carrying on past the end. It also fills the two-entry alert queue while the consumer stalls: a design with no real queue would overwrite the first alert or show the alerts in the wrong order, and a design with no full check would corrupt the head. Frames that must not configure anything, and words with channel code 0, are checked to leave writes and flags untouched.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 20;
    localparam int NODE_W = 8;
    localparam int NUM_CH = 3;
    localparam int CH_W   = 2;
    localparam logic [2:0] ALERT_TAG = 3'b100;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_ACTIVE,
        CH_LOCKED
    } ch_state_t;

    typedef struct packed {
        logic [NODE_W-1:0] dest;
        logic              dbl;
        logic [LEN_W-1:0]  len_m1;
        logic [ADDR_W-1:0] base;
    } chan_cfg_t;

    typedef struct packed {
        logic [NODE_W-1:0] dest;
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  len_m1;
    } alert_t;

    // Byte offset of a word index inside a buffer.
    function automatic logic [ADDR_W-1:0] word_offset(input logic [LEN_W-1:0] n);
        return {{(ADDR_W-LEN_W-2){1'b0}}, n, 2'b00};
    endfunction

    function automatic logic [31:0] alert_head_word(input logic [NODE_W-1:0] node,
                                                    input logic [LEN_W-1:0]  len_m1);
        return {node, ALERT_TAG, 1'b0, len_m1};
    endfunction

endpackage

// File: rtl/sbw_cfg_decode.sv
module sbw_cfg_decode
    import sbw_pkg::*;
(
    input  logic              cfg_valid,
    input  logic [31:0]       cfg_word0,
    input  logic [31:0]       cfg_word1,
    output logic [NUM_CH-1:0] load,
    output chan_cfg_t         cfg
);
    logic [CH_W-1:0] sel;
    logic            is_cfg;

    always_comb begin
        sel    = cfg_word0[22:21];
        is_cfg = cfg_valid && cfg_word0[23] && (sel != '0);
        for (int i = 0; i < NUM_CH; i++) begin
            load[i] = is_cfg && (sel == CH_W'(i + 1));
        end
        cfg.dest   = cfg_word0[31:24];
        cfg.dbl    = cfg_word0[20];
        cfg.len_m1 = cfg_word0[LEN_W-1:0];
        cfg.base   = {cfg_word1[ADDR_W-1:2], 2'b00};
    end
endmodule

// File: rtl/sbw_channel.sv
module sbw_channel
    import sbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  chan_cfg_t         cfg_in,
    input  logic              req,
    output logic              accept,
    output logic [ADDR_W-1:0] addr,
    output logic              fire,
    output alert_t            alert,
    output logic              ovf
);
    ch_state_t        state_q;
    chan_cfg_t        cfg_q;
    logic [LEN_W-1:0] idx_q;
    logic             ovf_q;

    logic [LEN_W:0]   len_full;
    logic [LEN_W-1:0] half;
    logic             at_end;
    logic             at_half;

    always_comb begin
        len_full = {1'b0, cfg_q.len_m1} + 1'b1;
        half     = len_full[LEN_W:1];
        at_end   = (idx_q == cfg_q.len_m1);
        at_half  = cfg_q.dbl && (half != '0) && (idx_q == half - 1'b1);
        accept   = req && (state_q == CH_ACTIVE) && !cfg_load;
        addr     = cfg_q.base + word_offset(idx_q);
        fire     = accept && (at_end || at_half);

        alert.dest = cfg_q.dest;
        if (at_half) begin
            alert.start  = cfg_q.base;
            alert.len_m1 = half - 1'b1;
        end else if (cfg_q.dbl) begin
            alert.start  = cfg_q.base + word_offset(half);
            alert.len_m1 = cfg_q.len_m1 - half;
        end else begin
            alert.start  = cfg_q.base;
            alert.len_m1 = cfg_q.len_m1;
        end
        ovf = ovf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
            ovf_q   <= 1'b0;
        end else if (cfg_load) begin
            state_q <= CH_ACTIVE;
            cfg_q   <= cfg_in;
            idx_q   <= '0;
            ovf_q   <= 1'b0;
        end else if (accept) begin
            if (at_end) begin
                idx_q <= '0;
                if (!cfg_q.dbl) begin
                    state_q <= CH_LOCKED;
                end
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (req) begin
            ovf_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sbw_alert_fifo.sv
module sbw_alert_fifo
    import sbw_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  alert_t din,
    input  logic   pop,
    output logic   valid,
    output alert_t dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    alert_t           mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             do_pop;
    logic             do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        valid   = (cnt_q != '0);
        full    = (cnt_q == CNT_W'(DEPTH));
        do_pop  = pop && valid;
        do_push = push && (!full || do_pop);
        dout    = mem_q[rd_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= din;
                wr_q        <= bump(wr_q);
            end
            if (do_pop) begin
                rd_q <= bump(rd_q);
            end
            if (do_push && !do_pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/stream_buf_writer.sv
module stream_buf_writer
    import sbw_pkg::*;
#(
    parameter int ALERT_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  node_addr,
    input  logic        cfg_valid,
    input  logic [31:0] cfg_word0,
    input  logic [31:0] cfg_word1,
    input  logic        dat_valid,
    input  logic [1:0]  dat_chan,
    input  logic [31:0] dat_word,
    output logic        wr_valid,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    output logic [2:0]  ovf_flag,
    output logic        alert_valid,
    input  logic        alert_ready,
    output logic [7:0]  alert_dest,
    output logic [31:0] alert_word0,
    output logic [31:0] alert_word1
);
    logic [NUM_CH-1:0] load;
    chan_cfg_t         cfg;
    logic [NUM_CH-1:0] ch_req;
    logic [NUM_CH-1:0] ch_accept;
    logic [NUM_CH-1:0] ch_fire;
    logic [ADDR_W-1:0] ch_addr  [NUM_CH];
    alert_t            ch_alert [NUM_CH];

    logic              any_accept;
    logic              any_fire;
    logic [ADDR_W-1:0] sel_addr;
    alert_t            sel_alert;
    alert_t            head;

    logic              wr_valid_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [31:0]       wr_data_q;

    sbw_cfg_decode u_dec (
        .cfg_valid (cfg_valid),
        .cfg_word0 (cfg_word0),
        .cfg_word1 (cfg_word1),
        .load      (load),
        .cfg       (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_req[g] = dat_valid && (dat_chan == CH_W'(g + 1));

        sbw_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .cfg_load (load[g]),
            .cfg_in   (cfg),
            .req      (ch_req[g]),
            .accept   (ch_accept[g]),
            .addr     (ch_addr[g]),
            .fire     (ch_fire[g]),
            .alert    (ch_alert[g]),
            .ovf      (ovf_flag[g])
        );
    end

    // At most one channel is requested per cycle, so a priority pick is exact.
    always_comb begin
        any_accept = |ch_accept;
        any_fire   = |ch_fire;
        sel_addr   = '0;
        sel_alert  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_accept[i]) begin
                sel_addr  = ch_addr[i];
                sel_alert = ch_alert[i];
            end
        end
    end

    sbw_alert_fifo #(.DEPTH(ALERT_DEPTH)) u_aq (
        .clk   (clk),
        .rst   (rst),
        .push  (any_fire),
        .din   (sel_alert),
        .pop   (alert_ready),
        .valid (alert_valid),
        .dout  (head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= any_accept;
            if (any_accept) begin
                wr_addr_q <= sel_addr;
                wr_data_q <= dat_word;
            end
        end
    end

    assign wr_valid    = wr_valid_q;
    assign wr_addr     = wr_addr_q;
    assign wr_data     = wr_data_q;
    assign alert_dest  = head.dest;
    assign alert_word0 = alert_head_word(node_addr, head.len_m1);
    assign alert_word1 = head.start;
endmodule

// File: rtl/stream_buf_writer_chk.sv
module stream_buf_writer_chk (
    input logic        clk,
    input logic        rst,
    input logic        dat_valid,
    input logic [1:0]  dat_chan,
    input logic        wr_valid,
    input logic [31:0] wr_addr,
    input logic [2:0]  ovf_flag,
    input logic        alert_valid,
    input logic        alert_ready,
    input logic [7:0]  alert_dest,
    input logic [31:0] alert_word0,
    input logic [31:0] alert_word1
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wr_valid && !alert_valid && ovf_flag == 3'b000)); // R1

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[1:0] == 2'b00)); // R3

    AST_ALERT_TAG: assert property (@(posedge clk) disable iff (rst)
        alert_valid |-> (alert_word0[23:20] == 4'b1000)); // R8

    AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (alert_valid && !alert_ready) |=>
            (alert_valid && $stable(alert_dest) && $stable(alert_word0) && $stable(alert_word1))); // R9

    AST_WRITE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ($past(dat_valid) && $past(dat_chan) != 2'b00)); // R10

    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        ((ovf_flag & ~$past(ovf_flag)) != 3'b000) |-> ($past(dat_valid) && !wr_valid)); // R7
endmodule

bind stream_buf_writer stream_buf_writer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dat_valid   (dat_valid),
    .dat_chan    (dat_chan),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .ovf_flag    (ovf_flag),
    .alert_valid (alert_valid),
    .alert_ready (alert_ready),
    .alert_dest  (alert_dest),
    .alert_word0 (alert_word0),
    .alert_word1 (alert_word1)
);

// File: tb/stream_buf_writer_tb.sv
module stream_buf_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] NODE = 8'hC3;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  node_addr;
    logic        cfg_valid;
    logic [31:0] cfg_word0;
    logic [31:0] cfg_word1;
    logic        dat_valid;
    logic [1:0]  dat_chan;
    logic [31:0] dat_word;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  ovf_flag;
    logic        alert_valid;
    logic        alert_ready;
    logic [7:0]  alert_dest;
    logic [31:0] alert_word0;
    logic [31:0] alert_word1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stream_buf_writer u_dut (
        .clk         (clk),
        .rst         (rst),
        .node_addr   (node_addr),
        .cfg_valid   (cfg_valid),
        .cfg_word0   (cfg_word0),
        .cfg_word1   (cfg_word1),
        .dat_valid   (dat_valid),
        .dat_chan    (dat_chan),
        .dat_word    (dat_word),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ovf_flag    (ovf_flag),
        .alert_valid (alert_valid),
        .alert_ready (alert_ready),
        .alert_dest  (alert_dest),
        .alert_word0 (alert_word0),
        .alert_word1 (alert_word1)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic configure(input logic [31:0] w0, input logic [31:0] w1);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_word0 = w0;
        cfg_word1 = w1;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // Presents one word; on return the registered write result is visible.
    task automatic send(input logic [1:0] ch, input logic [31:0] d);
        @(negedge clk);
        dat_valid = 1'b1;
        dat_chan  = ch;
        dat_word  = d;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic send_ok(input string req, input logic [1:0] ch, input logic [31:0] d,
                           input logic [31:0] exp_addr);
        send(ch, d);
        chk(req, "wr_valid", {31'b0, wr_valid}, 32'd1);
        chk(req, "wr_addr", wr_addr, exp_addr);
        chk(req, "wr_data", wr_data, d);
    endtask

    task automatic pop_alert;
        @(negedge clk);
        alert_ready = 1'b1;
        @(negedge clk);
        alert_ready = 1'b0;
    endtask

    task automatic chk_alert(input string req, input logic [7:0] dest,
                             input logic [19:0] len_m1, input logic [31:0] start);
        chk(req, "alert_valid", {31'b0, alert_valid}, 32'd1);
        chk(req, "alert_dest", {24'b0, alert_dest}, {24'b0, dest});
        chk(req, "alert_word0", alert_word0, {NODE, 3'b100, 1'b0, len_m1});
        chk(req, "alert_word1", alert_word1, start);
    endtask

    task automatic t_reset;
        chk("R1", "wr_valid", {31'b0, wr_valid}, 32'd0);
        chk("R1", "alert_valid", {31'b0, alert_valid}, 32'd0);
        chk("R1", "ovf_flag", {29'b0, ovf_flag}, 32'd0);
    endtask

    task automatic t_unconfigured;
        send(2'd2, 32'hAAAA_0001);
        chk("R7", "drop wr_valid", {31'b0, wr_valid}, 32'd0);
        chk("R7", "ovf_flag", {29'b0, ovf_flag}, 32'b010);
        // bit 23 clear: not a configure frame for channel 1
        configure(32'h5A23_0003, 32'h0000_1000);
        send(2'd1, 32'hAAAA_0002);
        chk("R2", "bit23 clear ignored", {31'b0, wr_valid}, 32'd0);
        // field 00: names no channel
        configure(32'h5A80_0003, 32'h0000_1000);
        send(2'd3, 32'hAAAA_0003);
        chk("R2", "field 00 ignored", {31'b0, wr_valid}, 32'd0);
        chk("R2", "ovf after ignored frames", {29'b0, ovf_flag}, 32'b111);
    endtask

    task automatic t_single;
        configure(32'h5AA0_0003, 32'h1000_0003);
        chk("R7", "configure clears flag", {29'b0, ovf_flag}, 32'b110);
        send_ok("R3", 2'd1, 32'h0000_0010, 32'h1000_0000);
        send_ok("R3", 2'd1, 32'h0000_0011, 32'h1000_0004);
        send_ok("R3", 2'd1, 32'h0000_0012, 32'h1000_0008);
        chk("R4", "no early alert", {31'b0, alert_valid}, 32'd0);
        send_ok("R3", 2'd1, 32'h0000_0013, 32'h1000_000C);
        chk_alert("R4", 8'h5A, 20'd3, 32'h1000_0000);
        chk_alert("R8", 8'h5A, 20'd3, 32'h1000_0000);
        send(2'd1, 32'h0000_0014);
        chk("R4", "locked drop", {31'b0, wr_valid}, 32'd0);
        chk("R4", "locked ovf", {29'b0, ovf_flag[0]}, 32'd1);
        pop_alert();
        chk("R9", "queue empty after pop", {31'b0, alert_valid}, 32'd0);
        // re-arm with a one-word buffer
        configure(32'h77A0_0000, 32'h0000_2000);
        chk("R7", "flag cleared on reconfigure", {31'b0, ovf_flag[0]}, 32'd0);
        send_ok("R7", 2'd1, 32'h0000_0020, 32'h0000_2000);
        chk_alert("R4", 8'h77, 20'd0, 32'h0000_2000);
        pop_alert();
    endtask

    task automatic t_double;
        // channel 3, double buffer, length 5 words, half = 2
        configure(32'h11F0_0004, 32'h0000_3000);
        send_ok("R3", 2'd3, 32'h0000_0030, 32'h0000_3000);
        chk("R5", "no alert before half", {31'b0, alert_valid}, 32'd0);
        send_ok("R3", 2'd3, 32'h0000_0031, 32'h0000_3004);
        chk_alert("R5", 8'h11, 20'd1, 32'h0000_3000);
        send(2'd0, 32'hDEAD_0000);
        chk("R10", "code 0 no write", {31'b0, wr_valid}, 32'd0);
        chk("R10", "code 0 no flag", {29'b0, ovf_flag}, 32'b010);
        send(2'd2, 32'hDEAD_0001);
        chk("R10", "channel 2 still idle", {31'b0, wr_valid}, 32'd0);
        send_ok("R3", 2'd3, 32'h0000_0032, 32'h0000_3008);
        send_ok("R3", 2'd3, 32'h0000_0033, 32'h0000_300C);
        send_ok("R3", 2'd3, 32'h0000_0034, 32'h0000_3010);
        send_ok("R6", 2'd3, 32'h0000_0035, 32'h0000_3000);
        // half alert again, but the queue is full: lost
        send_ok("R6", 2'd3, 32'h0000_0036, 32'h0000_3004);
        chk("R6", "double mode never flags", {31'b0, ovf_flag[2]}, 32'd0);
        chk_alert("R9", 8'h11, 20'd1, 32'h0000_3000);
        pop_alert();
        chk_alert("R6", 8'h11, 20'd2, 32'h0000_3008);
        pop_alert();
        chk("R9", "third alert lost", {31'b0, alert_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        node_addr   = NODE;
        cfg_valid   = 1'b0;
        cfg_word0   = '0;
        cfg_word1   = '0;
        dat_valid   = 1'b0;
        dat_chan    = '0;
        dat_word    = '0;
        alert_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unconfigured();
        t_single();
        t_double();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule